// File: doc/BRIEF.md
# Walking-Ones Data Bus Tester

This controller checks the data lines between the chip and an external memory for open or bridged traces. After a start request it writes a one-hot word to one fixed address and reads that address back. It then compares the read value with the written one and moves the single 1 up by one bit position. It repeats this for every data bit, so that a data fault is never mixed up with an address fault.

The test does not stop at the first error. Each step's mismatch is sorted into two accumulating diagnostic masks. The stuck mask flags a driven bit that came back as 0, which points to a line tied low or open toward ground. The short mask collects every unexpected 1 seen during any step, which points to lines bridged to the driven one. At the end a one-cycle done pulse is raised, and a pass flag is set when both masks are clear.

The state machine has five named states. IDLE waits for start. WRITE holds the write strobe until ready and then goes to READ. READ (the read-wait state) holds the read strobe until ready, captures the data and goes to CMP. CMP folds the step into the masks, then goes back to WRITE for the next bit or, after the top bit, to DONE. DONE lasts one cycle and returns to IDLE.

Top module: `dbus_walk_tester`

## Requirements
- R1: While reset is high and on the first cycle after it, the block sits in IDLE. The strobes, done and pass are low, and both masks are zero.
- R2: Every access, read or write, uses the address parameter TEST_ADDR (default 0).
- R3: Step k (k = 0 up to DW-1) writes the word with only bit k set, 1<<k, in increasing order, so every written word has exactly one bit high.
- R4: A strobe stays high with unchanged write data until ready is seen. Write and read strobes are never high together, and each accepted write is followed by an accepted read before the next write.
- R5: Bit k of the stuck mask is set when the read-back of step k has bit k equal to 0.
- R6: The short mask is the OR, over all steps, of the read-back bits other than the driven bit.
- R7: A run always performs exactly DW write and read pairs, whatever failures occur.
- R8: Done is high for exactly one cycle, directly after the last compare. From that cycle on, pass is 1 exactly when both masks are all zero.
- R9: A start accepted in IDLE clears both masks and pass before the first write of the new run.
- R10: Start is ignored outside IDLE, including in the cycle that carries the done pulse. No extra run starts and the masks keep their results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (sampled in IDLE) |
| mem_addr | output | AW | Memory address, fixed at TEST_ADDR |
| mem_wdata | output | DW | Write data (one-hot pattern) |
| mem_rdata | input | DW | Read data from memory |
| mem_wr | output | 1 | Write strobe, held until ready |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_ready | input | 1 | Memory accepts the current access |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Both masks clear after the run |
| stuck_mask | output | DW | Driven bits read back as 0 |
| short_mask | output | DW | Unexpected 1 bits seen across the run |

## Verification
Two events can fall in the same cycle: the done pulse that closes a run and a new start request. The bench raises start exactly in the done cycle, and also in the middle of a busy run. It then judges the outcome at the memory port and on the masks. No write may follow, no second done may appear, and the masks must still hold the results of the finished run. The memory model injects a stuck-low line and bridged pairs at several ready latencies, including zero wait, so that the ready input and a strobe rising coincide as well.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CMP,
        ST_DONE
    } dbt_state_e;
endpackage

// File: rtl/dbt_pattern_gen.sv
module dbt_pattern_gen #(
    parameter int DW = 8,
    localparam int SW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic [SW-1:0] step,
    output logic [DW-1:0] pattern
);
    // One decoder slice per data bit: a bit is high only at its own step.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign pattern[i] = (step == SW'(i));
    end
endmodule

// File: rtl/dbt_fault_classify.sv
module dbt_fault_classify #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] pattern,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] step_stuck,
    output logic [DW-1:0] step_short
);
    logic driven_seen;

    always_comb begin
        driven_seen = |(rdata & pattern);
        // The driven bit came back low: flag it as stuck low / grounded.
        step_stuck  = driven_seen ? '0 : pattern;
        // Any other 1 on the bus points to a bridge with the driven line.
        step_short  = rdata & ~pattern;
    end
endmodule

// File: rtl/dbus_walk_tester.sv
module dbus_walk_tester
    import dbt_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          AW        = 16,
    parameter logic [AW-1:0] TEST_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_wr,
    output logic          mem_rd,
    input  logic          mem_ready,
    output logic          done,
    output logic          pass,
    output logic [DW-1:0] stuck_mask,
    output logic [DW-1:0] short_mask
);
    localparam int SW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [SW-1:0] LAST_STEP = SW'(DW - 1);

    dbt_state_e    state_q, state_d;
    logic [SW-1:0] step_q;
    logic [DW-1:0] rd_q;
    logic [DW-1:0] stuck_q, short_q;
    logic          pass_q;
    logic [DW-1:0] pattern;
    logic [DW-1:0] step_stuck, step_short;
    logic          last_step;

    assign last_step = (step_q == LAST_STEP);

    dbt_pattern_gen #(.DW(DW)) u_pat (
        .step    (step_q),
        .pattern (pattern)
    );

    dbt_fault_classify #(.DW(DW)) u_cls (
        .pattern    (pattern),
        .rdata      (rd_q),
        .step_stuck (step_stuck),
        .step_short (step_short)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)     state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_CMP;
            ST_CMP:   state_d = last_step ? ST_DONE : ST_WRITE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Datapath: step counter, read capture, mask accumulation
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= '0;
            rd_q    <= '0;
            stuck_q <= '0;
            short_q <= '0;
            pass_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        step_q  <= '0;
                        stuck_q <= '0;
                        short_q <= '0;
                        pass_q  <= 1'b0;
                    end
                end
                ST_READ: begin
                    if (mem_ready) rd_q <= mem_rdata;
                end
                ST_CMP: begin
                    stuck_q <= stuck_q | step_stuck;
                    short_q <= short_q | step_short;
                    if (last_step) begin
                        pass_q <= ((stuck_q | step_stuck) == '0) &&
                                  ((short_q | step_short) == '0);
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_wr = 1'b0;
        mem_rd = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_WRITE: mem_wr = 1'b1;
            ST_READ:  mem_rd = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
    end

    assign mem_addr   = TEST_ADDR;
    assign mem_wdata  = pattern;
    assign pass       = pass_q;
    assign stuck_mask = stuck_q;
    assign short_mask = short_q;
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
    parameter int            DW        = 8,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] TEST_ADDR = '0
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic          mem_ready,
    input logic          done,
    input logic          pass,
    input logic [DW-1:0] stuck_mask,
    input logic [DW-1:0] short_mask
);
    // R2
    addr_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr || mem_rd) |-> (mem_addr == TEST_ADDR));

    // R3
    wdata_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($countones(mem_wdata) == 1));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr && mem_rd));

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_wdata)));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> mem_rd);

    // R4
    wr_then_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ready) |=> mem_rd);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    pass_match_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass == ((stuck_mask == '0) && (short_mask == '0))));
endmodule

bind dbus_walk_tester dbt_checker #(
    .DW(DW), .AW(AW), .TEST_ADDR(TEST_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_ready  (mem_ready),
    .done       (done),
    .pass       (pass),
    .stuck_mask (stuck_mask),
    .short_mask (short_mask)
);

// File: tb/dbus_walk_tester_tb.sv
`timescale 1ns/1ps
module dbus_walk_tester_tb;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam logic [AW-1:0] ADDR = 16'h0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_wr, mem_rd, mem_ready;
    logic          done, pass;
    logic [DW-1:0] stuck_mask, short_mask;

    always #2.5 clk = ~clk;

    dbus_walk_tester #(.DW(DW), .AW(AW), .TEST_ADDR(ADDR)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_ready(mem_ready),
        .done(done), .pass(pass),
        .stuck_mask(stuck_mask), .short_mask(short_mask)
    );

    // ---------------- memory model with injectable faults ----------------
    logic [DW-1:0] flt_stuck = '0;
    bit            flt_bridge = 1'b0;
    int            flt_a = 0, flt_b = 0;
    int            lat_cfg = 0;
    int            lat_cnt;
    logic [DW-1:0] mem_word;

    function automatic logic [DW-1:0] bus_model(input logic [DW-1:0] v);
        logic [DW-1:0] r = v;
        if (flt_bridge && (r[flt_a] || r[flt_b])) begin
            r[flt_a] = 1'b1;
            r[flt_b] = 1'b1;
        end
        return r & ~flt_stuck;
    endfunction

    assign mem_ready = (mem_wr || mem_rd) && (lat_cnt >= lat_cfg);
    always_comb mem_rdata = bus_model(mem_word);

    always @(posedge clk) begin
        if (rst) begin
            lat_cnt  <= 0;
            mem_word <= '0;
        end else begin
            if ((mem_wr || mem_rd) && !mem_ready) lat_cnt <= lat_cnt + 1;
            else                                  lat_cnt <= 0;
            if (mem_wr && mem_ready) mem_word <= mem_wdata;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [DW-1:0] st;
        logic [DW-1:0] sh;
        logic          ps;
    } res_t;

    logic [DW-1:0] wq[$];
    res_t          rq[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_wr && mem_ready) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R7 unexpected write", 32'(mem_wdata), 32'h0);
                end else begin
                    logic [DW-1:0] e;
                    e = wq.pop_front();
                    chk(mem_wdata == e, "R3 write pattern", 32'(mem_wdata), 32'(e));
                    chk(mem_addr == ADDR, "R2 write address", 32'(mem_addr), 32'(ADDR));
                end
            end
            if (mem_rd && mem_ready)
                chk(mem_addr == ADDR, "R2 read address", 32'(mem_addr), 32'(ADDR));
            if (done) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R10 unexpected done", 32'h1, 32'h0);
                end else begin
                    res_t r;
                    r = rq.pop_front();
                    chk(stuck_mask == r.st, "R5 stuck mask", 32'(stuck_mask), 32'(r.st));
                    chk(short_mask == r.sh, "R6 short mask", 32'(short_mask), 32'(r.sh));
                    chk(pass == r.ps, "R8 pass flag", 32'(pass), 32'(r.ps));
                    chk(wq.size() == 0, "R7 steps left", 32'(wq.size()), 32'h0);
                end
            end
        end
    end

    // Driver: configure faults, push expectations, run
    task automatic run_test(input logic [DW-1:0] stk, input bit ben, input int a,
                            input int b, input int lat, input bit poke_busy,
                            input bit poke_done);
        res_t          r;
        logic [DW-1:0] pat, rb;
        flt_stuck  = stk;
        flt_bridge = ben;
        flt_a      = a;
        flt_b      = b;
        lat_cfg    = lat;
        r.st = '0;
        r.sh = '0;
        for (int k = 0; k < DW; k++) begin
            pat = DW'(1) << k;
            wq.push_back(pat);
            rb = bus_model(pat);
            if (rb[k] == 1'b0) r.st[k] = 1'b1;
            r.sh = r.sh | (rb & ~pat);
        end
        r.ps = (r.st == '0) && (r.sh == '0);
        rq.push_back(r);

        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R9: masks and pass cleared, first write under way
        chk(stuck_mask == '0 && short_mask == '0 && pass == 1'b0,
            "R9 clear on start", {stuck_mask, short_mask, 7'd0, pass}, 32'h0);
        chk(mem_wr == 1'b1, "R9 first write", 32'(mem_wr), 32'h1);

        if (poke_busy) begin
            repeat (5) @(negedge clk);
            start = 1'b1;           // R10: start while busy
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (poke_done) begin
            start = 1'b1;           // R10: start in the done cycle
            @(negedge clk) start = 1'b0;
            for (int i = 0; i < 4; i++) begin
                chk(!mem_wr && !mem_rd && !done, "R10 no new run",
                    {29'd0, mem_wr, mem_rd, done}, 32'h0);
                chk(stuck_mask == r.st && short_mask == r.sh, "R10 masks kept",
                    {16'd0, stuck_mask, short_mask}, {16'd0, r.st, r.sh});
                @(negedge clk);
            end
        end else begin
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(!mem_wr && !mem_rd && !done && !pass, "R1 strobes in reset",
            {28'd0, mem_wr, mem_rd, done, pass}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(stuck_mask == '0 && short_mask == '0 && !mem_wr && !done, "R1 after reset",
            {16'd0, stuck_mask, short_mask}, 32'h0);

        // Clean bus, zero-wait memory
        run_test('0, 1'b0, 0, 0, 0, 1'b0, 1'b0);
        // Bit 1 stuck low plus bits 5 and 6 bridged, two wait cycles
        run_test(8'h02, 1'b1, 5, 6, 2, 1'b0, 1'b0);
        // Top bit stuck low, start pulsed mid-run (R10)
        run_test(8'h80, 1'b0, 0, 0, 0, 1'b1, 1'b0);
        // Bits 0 and 7 bridged, three wait cycles, start in the done cycle (R10)
        run_test('0, 1'b1, 0, 7, 3, 1'b0, 1'b1);
        // Clean again: masks from the last run must be cleared (R9)
        run_test('0, 1'b0, 0, 0, 1, 1'b0, 1'b0);

        chk(wq.size() == 0 && rq.size() == 0, "R7 scoreboard drained",
            32'(wq.size() + rq.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule